// File: doc/BRIEF.md
# UDP Destination-Port Demultiplexer

This block sits behind the IP receive layer of a network-attached reconfigurable device. It receives each UDP datagram as a 64-bit beat stream: the UDP header first, then the payload. The source IP address arrives as a sideband. On the first beat the block reads the destination port and settles where the whole datagram goes. Traffic on one of the two reconfiguration ports goes to the session engine stream. Traffic on any other port from a host that already holds a session goes to the user-application stream. Everything else is consumed and thrown away.

For every session the block keeps the peer's IP address and UDP source port in a small table, so the reply builder can address its answers. A reconfiguration datagram from a new host takes the lowest free entry. A datagram from a known host refreshes that host's port. The session engine frees an entry when a session ends. The block also counts the bytes of each datagram and flags a mismatch against the UDP length field on the last beat.

Top module: `udp_port_demux`

## Requirements
- R1: A datagram whose destination port (header beat bits [47:32]) is 49000 or 49001 appears beat for beat on the cfg stream. Every beat carries in `cfg_slot` the table entry of its sender.
- R2: A datagram on any other destination port, from a source IP held in a used table entry, appears beat for beat on the usr stream.
- R3: A datagram on a non-reconfiguration port from a source IP not in the table produces no output beat.
- R4: Dropped datagrams are consumed at one beat per cycle whatever `cfg_ready` and `usr_ready` are; `in_ready` stays high throughout.
- R5: A reconfiguration datagram from an IP already in the table rewrites that entry's port (source port, header bits [63:48]). One from a new IP fills the lowest-numbered free entry with its IP and source port.
- R6: A reconfiguration datagram from a new IP while every entry is in use is dropped, and the table is left unchanged.
- R7: The `err` bit is set on the last beat, and only there, when the bytes received (the popcount of `keep` over all beats, header included) differ from the length field (header bits [31:16]), or when that field exceeds 1480. `keep` bit i qualifies bits [8i+7:8i], and bit 7 is the first byte.
- R8: A pulse on `rel_valid` frees entry `rel_slot`. `rd_slot` reads back the used flag, IP and port of any entry, combinationally.
- R9: While an output is valid and not ready, its beat stays unchanged. Beats are neither lost nor reordered.
- R10: The route comes from the header beat alone and holds to the end of the datagram, even when later beats carry values that look like a port.
- R11: During and straight after reset no output is valid, `in_ready` is high and every table entry reads back as unused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted |
| in_data | input | 64 | Input beat, first byte in bits [63:56] |
| in_keep | input | 8 | Byte qualifiers of the input beat |
| in_sop | input | 1 | First beat (UDP header) |
| in_eop | input | 1 | Last beat |
| in_src_ip | input | 32 | Source IP of the datagram, sampled on the first beat |
| cfg_valid | output | 1 | Reconfiguration stream beat valid |
| cfg_ready | input | 1 | Reconfiguration stream ready |
| cfg_data | output | 64 | Reconfiguration stream data |
| cfg_keep | output | 8 | Reconfiguration stream byte qualifiers |
| cfg_sop | output | 1 | Reconfiguration stream first beat |
| cfg_eop | output | 1 | Reconfiguration stream last beat |
| cfg_err | output | 1 | Length error, on the last beat |
| cfg_slot | output | 1 | Table entry of the sender |
| usr_valid | output | 1 | User stream beat valid |
| usr_ready | input | 1 | User stream ready |
| usr_data | output | 64 | User stream data |
| usr_keep | output | 8 | User stream byte qualifiers |
| usr_sop | output | 1 | User stream first beat |
| usr_eop | output | 1 | User stream last beat |
| usr_err | output | 1 | Length error, on the last beat |
| rel_valid | input | 1 | Free a table entry |
| rel_slot | input | 1 | Entry to free |
| rd_slot | input | 1 | Entry to read back |
| rd_used | output | 1 | Entry in use |
| rd_ip | output | 32 | Peer IP of the entry |
| rd_port | output | 16 | Peer UDP port of the entry |

## Verification
The bench sends datagrams on both reconfiguration ports, on a user port from known and from unknown hosts, and on a reconfiguration port from a new host while the table is full. This separates the three routes from the table-full case. Single-beat, short, odd-length and maximum-size datagrams, each with a correct, short, long or oversize length field, show whether the byte count handles partial last beats and where the error bit lands. A user payload whose later beat holds 49000 in the port position shows whether the route is latched or decoded again on every beat. Random back-pressure on the outputs, along with drops sent while both outputs are stalled, separates holding an output beat from stalling the input.

// File: rtl/udpdmx_pkg.sv
package udpdmx_pkg;
  typedef enum logic [1:0] {
    DST_NONE = 2'd0,
    DST_CFG  = 2'd1,
    DST_USR  = 2'd2
  } dest_e;

  localparam int IP_W   = 32;
  localparam int PORT_W = 16;
  localparam int LEN_W  = 16;
endpackage

// File: rtl/udpdmx_peer_table.sv
module udpdmx_peer_table
  import udpdmx_pkg::*;
#(
  parameter int N  = 2,
  parameter int SW = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IP_W-1:0]   look_ip,
  output logic              hit,
  output logic [SW-1:0]     hit_slot,
  output logic              free_any,
  output logic [SW-1:0]     free_slot,
  input  logic              wr_en,
  input  logic [SW-1:0]     wr_slot,
  input  logic [IP_W-1:0]   wr_ip,
  input  logic [PORT_W-1:0] wr_port,
  input  logic              rel_en,
  input  logic [SW-1:0]     rel_slot,
  input  logic [SW-1:0]     rd_slot,
  output logic              rd_used,
  output logic [IP_W-1:0]   rd_ip,
  output logic [PORT_W-1:0] rd_port
);
  localparam int NP = 1 << SW;

  logic [NP-1:0]             used_all;
  logic [NP-1:0][IP_W-1:0]   ip_all;
  logic [NP-1:0][PORT_W-1:0] port_all;
  logic [NP-1:0]             match;

  for (genvar i = 0; i < NP; i++) begin : g_ent
    if (i < N) begin : g_real
      logic              used_q, used_d;
      logic [IP_W-1:0]   ip_q;
      logic [PORT_W-1:0] port_q;
      logic              wr_me, rel_me;

      always_comb begin
        wr_me  = wr_en && (wr_slot == SW'(i));
        rel_me = rel_en && (rel_slot == SW'(i));
        used_d = used_q;
        if (wr_me)       used_d = 1'b1;
        else if (rel_me) used_d = 1'b0;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          used_q <= 1'b0;
          ip_q   <= '0;
          port_q <= '0;
        end else begin
          used_q <= used_d;
          if (wr_me) begin
            ip_q   <= wr_ip;
            port_q <= wr_port;
          end
        end
      end

      assign used_all[i] = used_q;
      assign ip_all[i]   = ip_q;
      assign port_all[i] = port_q;
      assign match[i]    = used_q && (ip_q == look_ip);
    end else begin : g_pad
      assign used_all[i] = 1'b0;
      assign ip_all[i]   = '0;
      assign port_all[i] = '0;
      assign match[i]    = 1'b0;
    end
  end

  always_comb begin
    hit       = |match;
    hit_slot  = '0;
    free_any  = 1'b0;
    free_slot = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (match[i]) hit_slot = SW'(i);
      if (!used_all[i]) begin
        free_any  = 1'b1;
        free_slot = SW'(i);
      end
    end
  end

  assign rd_used = used_all[rd_slot];
  assign rd_ip   = ip_all[rd_slot];
  assign rd_port = port_all[rd_slot];
endmodule

// File: rtl/udpdmx_classify.sv
module udpdmx_classify
  import udpdmx_pkg::*;
#(
  parameter int SW         = 1,
  parameter int CFG_PORT_A = 49000,
  parameter int CFG_PORT_B = 49001
) (
  input  logic [PORT_W-1:0] dst_port,
  input  logic              hit,
  input  logic [SW-1:0]     hit_slot,
  input  logic              free_any,
  input  logic [SW-1:0]     free_slot,
  output dest_e             dest,
  output logic [SW-1:0]     slot,
  output logic              learn
);
  logic is_cfg;

  always_comb begin
    is_cfg = (dst_port == PORT_W'(CFG_PORT_A)) || (dst_port == PORT_W'(CFG_PORT_B));
    dest   = DST_NONE;
    slot   = '0;
    learn  = 1'b0;
    if (is_cfg) begin
      if (hit) begin
        dest  = DST_CFG;
        slot  = hit_slot;
        learn = 1'b1;
      end else if (free_any) begin
        dest  = DST_CFG;
        slot  = free_slot;
        learn = 1'b1;
      end
    end else if (hit) begin
      dest = DST_USR;
      slot = hit_slot;
    end
  end
endmodule

// File: rtl/udpdmx_len_check.sv
module udpdmx_len_check
  import udpdmx_pkg::*;
#(
  parameter int KW      = 8,
  parameter int MAX_LEN = 1480
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             sop,
  input  logic             eop,
  input  logic [KW-1:0]    keep,
  input  logic [LEN_W-1:0] len_in,
  output logic             err
);
  logic [LEN_W-1:0] acc_q, acc_d, len_q, len_d;
  logic [LEN_W-1:0] base, exp_len, total;

  always_comb begin
    base    = sop ? '0 : acc_q;
    exp_len = sop ? len_in : len_q;
    total   = base + LEN_W'($countones(keep));
    err     = eop && ((total != exp_len) || (exp_len > LEN_W'(MAX_LEN)));
    acc_d   = acc_q;
    len_d   = len_q;
    if (step) begin
      acc_d = total;
      len_d = exp_len;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      len_q <= '0;
    end else if (step) begin
      acc_q <= acc_d;
      len_q <= len_d;
    end
  end
endmodule

// File: rtl/udp_port_demux.sv
module udp_port_demux
  import udpdmx_pkg::*;
#(
  parameter int DATA_W     = 64,
  parameter int NUM_PEERS  = 2,
  parameter int CFG_PORT_A = 49000,
  parameter int CFG_PORT_B = 49001,
  parameter int MAX_LEN    = 1480,
  localparam int KW        = DATA_W / 8,
  localparam int SW        = (NUM_PEERS > 1) ? $clog2(NUM_PEERS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic [KW-1:0]     in_keep,
  input  logic              in_sop,
  input  logic              in_eop,
  input  logic [31:0]       in_src_ip,
  output logic              cfg_valid,
  input  logic              cfg_ready,
  output logic [DATA_W-1:0] cfg_data,
  output logic [KW-1:0]     cfg_keep,
  output logic              cfg_sop,
  output logic              cfg_eop,
  output logic              cfg_err,
  output logic [SW-1:0]     cfg_slot,
  output logic              usr_valid,
  input  logic              usr_ready,
  output logic [DATA_W-1:0] usr_data,
  output logic [KW-1:0]     usr_keep,
  output logic              usr_sop,
  output logic              usr_eop,
  output logic              usr_err,
  input  logic              rel_valid,
  input  logic [SW-1:0]     rel_slot,
  input  logic [SW-1:0]     rd_slot,
  output logic              rd_used,
  output logic [31:0]       rd_ip,
  output logic [15:0]       rd_port
);
  localparam int SP_LSB = DATA_W - 16;
  localparam int DP_LSB = DATA_W - 32;
  localparam int LN_LSB = DATA_W - 48;

  logic [PORT_W-1:0] hdr_sport, hdr_dport;
  logic [LEN_W-1:0]  hdr_len;
  logic              tb_hit, tb_free;
  logic [SW-1:0]     tb_hit_slot, tb_free_slot;
  dest_e             cls_dest;
  logic [SW-1:0]     cls_slot;
  logic              cls_learn;
  logic              beat_err;

  dest_e             dest_q, dest_d, beat_dest;
  logic [SW-1:0]     slot_q, slot_d, beat_slot;

  logic              hold_v_q, hold_v_d;
  logic [DATA_W-1:0] hold_data_q;
  logic [KW-1:0]     hold_keep_q;
  logic              hold_sop_q, hold_eop_q, hold_err_q;
  dest_e             hold_dest_q;
  logic [SW-1:0]     hold_slot_q;

  logic              accept, drain, learn_en;

  assign hdr_sport = in_data[SP_LSB +: PORT_W];
  assign hdr_dport = in_data[DP_LSB +: PORT_W];
  assign hdr_len   = in_data[LN_LSB +: LEN_W];

  udpdmx_peer_table #(.N(NUM_PEERS), .SW(SW)) u_table (
    .clk       (clk),
    .rst_n     (rst_n),
    .look_ip   (in_src_ip),
    .hit       (tb_hit),
    .hit_slot  (tb_hit_slot),
    .free_any  (tb_free),
    .free_slot (tb_free_slot),
    .wr_en     (learn_en),
    .wr_slot   (cls_slot),
    .wr_ip     (in_src_ip),
    .wr_port   (hdr_sport),
    .rel_en    (rel_valid),
    .rel_slot  (rel_slot),
    .rd_slot   (rd_slot),
    .rd_used   (rd_used),
    .rd_ip     (rd_ip),
    .rd_port   (rd_port)
  );

  udpdmx_classify #(.SW(SW), .CFG_PORT_A(CFG_PORT_A), .CFG_PORT_B(CFG_PORT_B)) u_cls (
    .dst_port  (hdr_dport),
    .hit       (tb_hit),
    .hit_slot  (tb_hit_slot),
    .free_any  (tb_free),
    .free_slot (tb_free_slot),
    .dest      (cls_dest),
    .slot      (cls_slot),
    .learn     (cls_learn)
  );

  udpdmx_len_check #(.KW(KW), .MAX_LEN(MAX_LEN)) u_len (
    .clk    (clk),
    .rst_n  (rst_n),
    .step   (accept),
    .sop    (in_sop),
    .eop    (in_eop),
    .keep   (in_keep),
    .len_in (hdr_len),
    .err    (beat_err)
  );

  // Next-state logic: route latch and single output holding stage.
  always_comb begin
    drain = hold_v_q && ((hold_dest_q == DST_NONE) ||
                         ((hold_dest_q == DST_CFG) && cfg_ready) ||
                         ((hold_dest_q == DST_USR) && usr_ready));
    in_ready  = !hold_v_q || drain;
    accept    = in_valid && in_ready;
    beat_dest = in_sop ? cls_dest : dest_q;
    beat_slot = in_sop ? cls_slot : slot_q;
    learn_en  = accept && in_sop && cls_learn;
    dest_d    = dest_q;
    slot_d    = slot_q;
    if (accept && in_sop) begin
      dest_d = cls_dest;
      slot_d = cls_slot;
    end
    hold_v_d = hold_v_q;
    if (accept)     hold_v_d = 1'b1;
    else if (drain) hold_v_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dest_q <= DST_NONE;
      slot_q <= '0;
    end else if (accept && in_sop) begin
      dest_q <= dest_d;
      slot_q <= slot_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_v_q <= 1'b0;
    end else begin
      hold_v_q <= hold_v_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_data_q <= '0;
      hold_keep_q <= '0;
      hold_sop_q  <= 1'b0;
      hold_eop_q  <= 1'b0;
      hold_err_q  <= 1'b0;
      hold_dest_q <= DST_NONE;
      hold_slot_q <= '0;
    end else if (accept) begin
      hold_data_q <= in_data;
      hold_keep_q <= in_keep;
      hold_sop_q  <= in_sop;
      hold_eop_q  <= in_eop;
      hold_err_q  <= beat_err;
      hold_dest_q <= beat_dest;
      hold_slot_q <= beat_slot;
    end
  end

  assign cfg_valid = hold_v_q && (hold_dest_q == DST_CFG);
  assign cfg_data  = hold_data_q;
  assign cfg_keep  = hold_keep_q;
  assign cfg_sop   = hold_sop_q;
  assign cfg_eop   = hold_eop_q;
  assign cfg_err   = hold_err_q;
  assign cfg_slot  = hold_slot_q;

  assign usr_valid = hold_v_q && (hold_dest_q == DST_USR);
  assign usr_data  = hold_data_q;
  assign usr_keep  = hold_keep_q;
  assign usr_sop   = hold_sop_q;
  assign usr_eop   = hold_eop_q;
  assign usr_err   = hold_err_q;
endmodule

// File: rtl/udp_port_demux_sva.sv
module udp_port_demux_sva #(
  parameter int DATA_W     = 64,
  parameter int CFG_PORT_A = 49000,
  parameter int CFG_PORT_B = 49001
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              cfg_valid,
  input logic              cfg_ready,
  input logic [DATA_W-1:0] cfg_data,
  input logic              cfg_sop,
  input logic              cfg_eop,
  input logic              cfg_err,
  input logic              usr_valid,
  input logic              usr_ready,
  input logic [DATA_W-1:0] usr_data,
  input logic              usr_sop,
  input logic              usr_eop,
  input logic              usr_err
);
  localparam int DP_LSB = DATA_W - 32;

  assert_one_route_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_valid && usr_valid));

  assert_cfg_port_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && cfg_sop) |->
      ((cfg_data[DP_LSB +: 16] == 16'(CFG_PORT_A)) || (cfg_data[DP_LSB +: 16] == 16'(CFG_PORT_B))));

  assert_usr_port_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (usr_valid && usr_sop) |->
      ((usr_data[DP_LSB +: 16] != 16'(CFG_PORT_A)) && (usr_data[DP_LSB +: 16] != 16'(CFG_PORT_B))));

  assert_drop_no_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !cfg_valid && !usr_valid) |-> in_ready);

  assert_cfg_err_eop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && cfg_err) |-> cfg_eop);

  assert_usr_err_eop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (usr_valid && usr_err) |-> usr_eop);

  assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && !cfg_ready) |=> (cfg_valid && $stable(cfg_data) && $stable(cfg_eop)));

  assert_usr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (usr_valid && !usr_ready) |=> (usr_valid && $stable(usr_data) && $stable(usr_eop)));
endmodule

bind udp_port_demux udp_port_demux_sva #(
  .DATA_W(DATA_W), .CFG_PORT_A(CFG_PORT_A), .CFG_PORT_B(CFG_PORT_B)
) u_sva (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .cfg_valid(cfg_valid), .cfg_ready(cfg_ready), .cfg_data(cfg_data),
  .cfg_sop(cfg_sop), .cfg_eop(cfg_eop), .cfg_err(cfg_err),
  .usr_valid(usr_valid), .usr_ready(usr_ready), .usr_data(usr_data),
  .usr_sop(usr_sop), .usr_eop(usr_eop), .usr_err(usr_err)
);

// File: tb/udp_port_demux_bench.sv
`timescale 1ns/1ps
module udp_port_demux_bench;
  localparam int SW = 1;
  typedef struct packed {
    logic [63:0]   d;
    logic          s;
    logic          e;
    logic [7:0]    k;
    logic          err;
    logic [SW-1:0] slot;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
  logic [63:0] in_data = '0;
  logic [7:0] in_keep = '0;
  logic [31:0] in_src_ip = '0;
  logic in_ready;
  logic cfg_valid, cfg_sop, cfg_eop, cfg_err;
  logic cfg_ready = 1'b1;
  logic [63:0] cfg_data;
  logic [7:0] cfg_keep;
  logic [SW-1:0] cfg_slot;
  logic usr_valid, usr_sop, usr_eop, usr_err;
  logic usr_ready = 1'b1;
  logic [63:0] usr_data;
  logic [7:0] usr_keep;
  logic rel_valid = 1'b0;
  logic [SW-1:0] rel_slot = '0, rd_slot = '0;
  logic rd_used;
  logic [31:0] rd_ip;
  logic [15:0] rd_port;

  always #2.5 clk = ~clk;

  udp_port_demux u_udp_port_demux (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_keep(in_keep),
    .in_sop(in_sop), .in_eop(in_eop), .in_src_ip(in_src_ip),
    .cfg_valid(cfg_valid), .cfg_ready(cfg_ready), .cfg_data(cfg_data), .cfg_keep(cfg_keep),
    .cfg_sop(cfg_sop), .cfg_eop(cfg_eop), .cfg_err(cfg_err), .cfg_slot(cfg_slot),
    .usr_valid(usr_valid), .usr_ready(usr_ready), .usr_data(usr_data), .usr_keep(usr_keep),
    .usr_sop(usr_sop), .usr_eop(usr_eop), .usr_err(usr_err),
    .rel_valid(rel_valid), .rel_slot(rel_slot), .rd_slot(rd_slot),
    .rd_used(rd_used), .rd_ip(rd_ip), .rd_port(rd_port)
  );

  int n_checks = 0, n_fails = 0, stalls = 0;
  bit finished = 0, bp_en = 0, force_low = 0, fill_port = 0;
  logic [15:0] lfsr = 16'hACE1;
  item_t cfg_q[$], usr_q[$];
  bit m_used[2];
  logic [31:0] m_ip[2];
  logic [15:0] m_port[2];

  task automatic check(input bit ok, input string req, input logic [79:0] act, input logic [79:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Ready generation, changed just after each rising edge.
  always @(posedge clk) begin
    #1;
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (force_low) begin
      cfg_ready <= 1'b0; usr_ready <= 1'b0;
    end else if (bp_en) begin
      cfg_ready <= lfsr[0]; usr_ready <= lfsr[3];
    end else begin
      cfg_ready <= 1'b1; usr_ready <= 1'b1;
    end
  end

  // Monitor: compare every handshaken beat with the scoreboard.
  always @(negedge clk) begin
    item_t got, exp;
    if (rst_n && !finished) begin
      if (cfg_valid && cfg_ready) begin
        got = {cfg_data, cfg_sop, cfg_eop, cfg_keep, cfg_err, cfg_slot};
        if (cfg_q.size() == 0) check(0, "R3 R6 unexpected cfg beat", 80'(got), 80'(0));
        else begin
          exp = cfg_q.pop_front();
          check(got == exp, "R1 R5 R7 R9 cfg beat", 80'(got), 80'(exp));
        end
      end
      if (usr_valid && usr_ready) begin
        got = {usr_data, usr_sop, usr_eop, usr_keep, usr_err, {SW{1'b0}}};
        if (usr_q.size() == 0) check(0, "R3 unexpected usr beat", 80'(got), 80'(0));
        else begin
          exp = usr_q.pop_front();
          check(got == exp, "R2 R7 R9 R10 usr beat", 80'(got), 80'(exp));
        end
      end
    end
  end

  task automatic send(input logic [31:0] ip, input logic [15:0] sp, input logic [15:0] dp,
                      input int npay, input int len_delta);
    int total, lenf, nb, hit, fr, slot;
    bit is_cfg, exp_err;
    int dest; // 0 none, 1 cfg, 2 usr
    total = 8 + npay;
    lenf = total + len_delta;
    exp_err = (total != lenf) || (lenf > 1480);
    is_cfg = (dp == 16'd49000) || (dp == 16'd49001);
    hit = -1; fr = -1;
    for (int i = 1; i >= 0; i--) begin
      if (m_used[i] && m_ip[i] == ip) hit = i;
      if (!m_used[i]) fr = i;
    end
    dest = 0; slot = 0;
    if (is_cfg && hit >= 0) begin dest = 1; slot = hit; end
    else if (is_cfg && fr >= 0) begin dest = 1; slot = fr; end
    else if (!is_cfg && hit >= 0) dest = 2;
    nb = (total + 7) / 8;
    for (int b = 0; b < nb; b++) begin
      item_t it;
      int left;
      left = total - b * 8;
      it.d = '0; it.k = '0;
      if (b == 0) it.d = {sp, dp, 16'(lenf), 16'h0000};
      for (int k = 0; k < 8; k++) begin
        if (k < left) begin
          it.k[7-k] = 1'b1;
          if (b > 0) it.d[63-8*k -: 8] = fill_port ? ((k % 2 == 0) ? 8'hBF : 8'h68)
                                                   : 8'((b * 8 + k) * 7 + 3);
        end
      end
      it.s = (b == 0);
      it.e = (b == nb - 1);
      it.err = it.e && exp_err;
      it.slot = (dest == 1) ? SW'(slot) : '0;
      if (dest == 1) cfg_q.push_back(it);
      if (dest == 2) usr_q.push_back(it);
      @(posedge clk); #1;
      in_valid = 1'b1; in_data = it.d; in_keep = it.k;
      in_sop = it.s; in_eop = it.e; in_src_ip = ip;
      forever begin
        @(negedge clk);
        if (in_ready) break;
        stalls++;
      end
    end
    @(posedge clk); #1;
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
    if (dest == 1) begin
      m_used[slot] = 1; m_ip[slot] = ip; m_port[slot] = sp;
    end
  endtask

  task automatic drain();
    for (int i = 0; i < 2000; i++) begin
      if (cfg_q.size() == 0 && usr_q.size() == 0) break;
      @(negedge clk);
    end
    repeat (3) @(negedge clk);
    check(cfg_q.size() == 0 && usr_q.size() == 0, "R9 all expected beats delivered",
          80'(cfg_q.size() + usr_q.size()), 80'(0));
  endtask

  task automatic chk_tbl(input int s, input string req);
    @(negedge clk);
    rd_slot = SW'(s);
    #1;
    check(rd_used == m_used[s], req, 80'(rd_used), 80'(m_used[s]));
    if (m_used[s])
      check({rd_ip, rd_port} == {m_ip[s], m_port[s]}, req,
            80'({rd_ip, rd_port}), 80'({m_ip[s], m_port[s]}));
  endtask

  task automatic release_slot(input int s);
    @(posedge clk); #1;
    rel_valid = 1'b1; rel_slot = SW'(s);
    @(posedge clk); #1;
    rel_valid = 1'b0;
    m_used[s] = 0;
  endtask

  initial begin
    repeat (1000000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++; n_fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  localparam logic [31:0] IPA = 32'h0A00_0001, IPB = 32'h0A00_0002, IPC = 32'h0A00_0003;

  initial begin
    for (int i = 0; i < 2; i++) m_used[i] = 0;
    repeat (3) @(negedge clk);
    // R11: reset state
    check(!cfg_valid && !usr_valid, "R11 outputs idle in reset", 80'({cfg_valid, usr_valid}), 80'(0));
    check(in_ready, "R11 ready in reset", 80'(in_ready), 80'(1));
    rst_n = 1'b1;
    @(negedge clk);
    check(!cfg_valid && !usr_valid && in_ready, "R11 idle after reset",
          80'({cfg_valid, usr_valid, in_ready}), 80'(1));
    chk_tbl(0, "R11 entry 0 empty");
    chk_tbl(1, "R11 entry 1 empty");

    // R1 R5: sessions learned into free entries
    send(IPA, 16'd5000, 16'd49000, 20, 0); drain(); chk_tbl(0, "R5 learn A");
    send(IPB, 16'd6000, 16'd49001, 0, 0);  drain(); chk_tbl(1, "R5 learn B");

    // R2 R10: user traffic from known host; later beat mimics port 49000
    fill_port = 1;
    send(IPA, 16'd7000, 16'd49200, 30, 0); drain();
    fill_port = 0;

    // R3 R4: unknown host on user port, outputs stalled, input never stalls
    force_low = 1; repeat (2) @(negedge clk);
    stalls = 0;
    send(IPC, 16'd8000, 16'd49200, 33, 0);
    check(stalls == 0, "R4 dropped datagram not stalled", 80'(stalls), 80'(0));
    // R6: new host with full table
    send(IPC, 16'd8000, 16'd49000, 12, 0);
    check(stalls == 0, "R4 R6 table-full drop not stalled", 80'(stalls), 80'(0));
    force_low = 0; drain();
    chk_tbl(0, "R6 entry 0 unchanged");
    chk_tbl(1, "R6 entry 1 unchanged");

    // R5: known host refreshes its port in the same entry
    send(IPA, 16'd5100, 16'd49001, 13, 0); drain(); chk_tbl(0, "R5 port refresh");

    // R7: length field checks
    send(IPA, 16'd5100, 16'd49000, 16, 3);  drain();
    send(IPA, 16'd5100, 16'd49300, 5, -1);  drain();
    send(IPB, 16'd6000, 16'd49000, 1472, 0); drain();
    send(IPB, 16'd6000, 16'd49000, 1480, 0); drain();
    send(IPA, 16'd5100, 16'd49000, 0, 8);   drain();

    // R8: release entry 1; B becomes unknown, C can take the entry
    release_slot(1);
    chk_tbl(1, "R8 entry 1 freed");
    send(IPB, 16'd6000, 16'd49200, 9, 0); drain();
    send(IPC, 16'd8100, 16'd49000, 7, 0); drain(); chk_tbl(1, "R8 R5 reuse freed entry");

    // R9: random back-pressure on both outputs
    bp_en = 1;
    for (int i = 0; i < 12; i++) begin
      send((i % 2) ? IPA : IPC, 16'd5100 + 16'(i), (i % 3 == 0) ? 16'd49200 : 16'd49001, 5 + 11 * i, 0);
    end
    drain();
    bp_en = 0;
    chk_tbl(0, "R5 R9 entry 0 after stress");

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule